// File: doc/BRIEF.md
# Fetch Group Queue

The fetch group queue sits between an instruction fetch stage and a decode stage. Each cycle the fetch side may offer a group of up to four instruction words. The queue accepts the group only if all of it fits. In the same cycle the decode side may consume up to two instructions from the head. The words leave in exactly the order they arrived: lane 0 of a write group is the oldest word of that group.

Storage is a circular array of twelve slots, with a head pointer and a tail pointer that both wrap modulo twelve. Entries never move once written. The fetch stage uses the free-slot output as backpressure. A flush, raised on a branch redirect or on an exceptional instruction, discards everything held, and the queue is empty on the following cycle.

Top module: `fetch_group_queue`

## Requirements
- R1: When `wr_cnt` is between 1 and 4 and no greater than `free_cnt`, words `wr_data` lanes 0 to `wr_cnt`-1 (lane k at bits k*32 +: 32) are appended behind all queued words, in lane order, lowest lane first.
- R2: The queue holds at most 12 words. `free_cnt` equals 12 minus the number of words held. After a synchronous active-low reset, `free_cnt` is 12 and `rd_valid` is 0.
- R3: `rd_data` lane 0 (bits 31:0) shows the oldest held word and lane 1 (bits 63:32) shows the next oldest. `rd_cnt` removes min(`rd_cnt`, 2, words held) words from the head at the clock edge, so the values 2 and 3 both consume at most two.
- R4: `rd_valid[0]` is 1 exactly when at least one word is held, and `rd_valid[1]` is 1 exactly when at least two words are held.
- R5: A cycle with `flush` high empties the queue by the next cycle (`free_cnt` = 12, `rd_valid` = 0). A write or read in that cycle has no effect.
- R6: A write and a read in the same cycle both take effect. The occupancy changes by the accepted write count minus the consumed read count. Whether the write is accepted is judged against `free_cnt` before that cycle's read.
- R7: A write with `wr_cnt` greater than `free_cnt`, or greater than 4, is refused as a whole: none of its words is stored.
- R8: Order and contents are preserved when the head or the tail wraps from slot 11 back to slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all held words |
| wr_cnt | input | 3 | Number of valid write lanes in this group |
| wr_data | input | 128 | Four write lanes of 32 bits, lane 0 in the low bits |
| rd_cnt | input | 2 | Number of words decode takes this cycle |
| rd_data | output | 64 | Two oldest words, oldest in the low bits |
| rd_valid | output | 2 | Per-lane valid flags for `rd_data` |
| free_cnt | output | 4 | Number of empty slots |

## Verification
On every cycle the assertions check the following: the occupancy bound, the pointer and count consistency across wrap, the ordering of the two valid flags, the empty state after a flush, the net change of the free count on a legal write and read, and that the free count stays the same on a refused write. The assertions cannot see which words are stored or in which order they come out. Only the bench scenarios show that, by comparing both read lanes against an arithmetic model. They sweep every write count, read count and flush value from every occupancy, with the head moved to several starting slots so that wraps occur.

// File: rtl/fgq_pkg.sv
// Package fgq_pkg
// Shared helpers for the fetch group queue.
// Assumes: pointer arithmetic operands are below twice the depth.
package fgq_pkg;

    // Modulo add for ring pointers; base < depth and inc <= depth assumed.
    function automatic int unsigned ring_add(int unsigned base, int unsigned inc,
                                             int unsigned depth);
        int unsigned sum;
        sum = base + inc;
        if (sum >= depth) sum = sum - depth;
        return sum;
    endfunction

endpackage

// File: rtl/fgq_ptr_ctrl.sv
// Module fgq_ptr_ctrl
// Holds the head pointer, the tail pointer and the occupancy of the ring.
// It decides how many write lanes are accepted (all or none) and how many
// reads are honoured (clamped to lane count and occupancy).
// Assumes: flush has priority over every other update; reset is synchronous, active low.
module fgq_ptr_ctrl #(
    parameter int DEPTH    = 12,
    parameter int WR_LANES = 4,
    parameter int RD_LANES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [$clog2(WR_LANES+1)-1:0]     wr_cnt,
    input  logic [$clog2(RD_LANES+1)-1:0]     rd_cnt,
    output logic [$clog2(WR_LANES+1)-1:0]     wr_eff,
    output logic [$clog2(DEPTH)-1:0]          head,
    output logic [$clog2(DEPTH)-1:0]          tail,
    output logic [$clog2(DEPTH+1)-1:0]        occ
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int WC_W  = $clog2(WR_LANES+1);
    localparam int RC_W  = $clog2(RD_LANES+1);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] occ_q;
    logic [RC_W-1:0]  rd_eff;
    int unsigned      free_slots;

    // Whole-group write acceptance against current free space.
    always_comb begin
        free_slots = DEPTH - int'(occ_q);
        if (int'(wr_cnt) <= WR_LANES && int'(wr_cnt) <= free_slots)
            wr_eff = wr_cnt;
        else
            wr_eff = '0;
    end

    // Read consumption clamped to lane count and to what is held.
    always_comb begin
        int unsigned take;
        take = int'(rd_cnt);
        if (take > RD_LANES) take = RD_LANES;
        if (take > int'(occ_q)) take = int'(occ_q);
        rd_eff = RC_W'(take);
    end

    // Pointer and occupancy registers with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            head_q <= PTR_W'(fgq_pkg::ring_add(int'(head_q), int'(rd_eff), DEPTH));
            tail_q <= PTR_W'(fgq_pkg::ring_add(int'(tail_q), int'(wr_eff), DEPTH));
            occ_q  <= occ_q + CNT_W'(wr_eff) - CNT_W'(rd_eff);
        end
    end

    assign head = head_q;
    assign tail = tail_q;
    assign occ  = occ_q;

    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_q) <= DEPTH); // R2
    AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(head_q) < DEPTH && int'(tail_q) < DEPTH); // R8
    AST_TAIL_TRACKS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tail_q) == int'(fgq_pkg::ring_add(int'(head_q), int'(occ_q), DEPTH))); // R8

endmodule

// File: rtl/fgq_slot_array.sv
// Module fgq_slot_array
// Ring storage for the queue. Accepted write lanes land in consecutive
// slots from the tail, wrapping modulo DEPTH. The read lanes show the slots
// from the head onward. Entries never shift.
// Assumes: wr_eff never exceeds free space (checked upstream); data slots
// carry no reset because the valid flags mask unwritten contents.
module fgq_slot_array #(
    parameter int DEPTH    = 12,
    parameter int WR_LANES = 4,
    parameter int RD_LANES = 2,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic [$clog2(WR_LANES+1)-1:0]    wr_eff,
    input  logic [$clog2(DEPTH)-1:0]         tail,
    input  logic [$clog2(DEPTH)-1:0]         head,
    input  logic [WR_LANES*DATA_W-1:0]       wr_data,
    output logic [RD_LANES*DATA_W-1:0]       rd_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] slots [DEPTH];

    // Scatter accepted write lanes into ring slots starting at tail.
    always_ff @(posedge clk) begin
        for (int l = 0; l < WR_LANES; l++) begin
            if (l < int'(wr_eff))
                slots[PTR_W'(fgq_pkg::ring_add(int'(tail), l, DEPTH))]
                    <= wr_data[l*DATA_W +: DATA_W];
        end
    end

    // One read mux per output lane, offset from head.
    for (genvar k = 0; k < RD_LANES; k++) begin : g_rd_lane
        logic [PTR_W-1:0] slot_idx;
        assign slot_idx = PTR_W'(fgq_pkg::ring_add(int'(head), k, DEPTH));
        assign rd_data[k*DATA_W +: DATA_W] = slots[slot_idx];
    end

endmodule

// File: rtl/fetch_group_queue.sv
// Module fetch_group_queue
// Instruction buffer between fetch and decode. It takes up to WR_LANES words
// per cycle and shows the RD_LANES oldest words. It reports free slots for
// backpressure, and a flush empties it.
// Assumes: synchronous active-low reset; flush outranks a same-cycle write or read.
module fetch_group_queue #(
    parameter int DEPTH    = 12,
    parameter int WR_LANES = 4,
    parameter int RD_LANES = 2,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [$clog2(WR_LANES+1)-1:0]    wr_cnt,
    input  logic [WR_LANES*DATA_W-1:0]       wr_data,
    input  logic [$clog2(RD_LANES+1)-1:0]    rd_cnt,
    output logic [RD_LANES*DATA_W-1:0]       rd_data,
    output logic [RD_LANES-1:0]              rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]       free_cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int WC_W  = $clog2(WR_LANES+1);

    logic [WC_W-1:0]  wr_eff;
    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] occ;

    fgq_ptr_ctrl #(
        .DEPTH(DEPTH), .WR_LANES(WR_LANES), .RD_LANES(RD_LANES)
    ) i_ptr (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
        .wr_eff(wr_eff), .head(head), .tail(tail), .occ(occ)
    );

    fgq_slot_array #(
        .DEPTH(DEPTH), .WR_LANES(WR_LANES), .RD_LANES(RD_LANES), .DATA_W(DATA_W)
    ) i_slots (
        .clk(clk), .wr_eff(wr_eff), .tail(tail), .head(head),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    // Per-lane valid flags from occupancy.
    for (genvar k = 0; k < RD_LANES; k++) begin : g_valid
        assign rd_valid[k] = (int'(occ) > k);
    end

    // Free-slot count for fetch backpressure.
    assign free_cnt = CNT_W'(DEPTH) - occ;

    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid[RD_LANES-1:1] != '0) |-> rd_valid[0]); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (int'(free_cnt) == DEPTH && rd_valid == '0)); // R5
    AST_NET_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && int'(wr_cnt) <= WR_LANES && wr_cnt <= free_cnt
         && int'(rd_cnt) <= $countones(rd_valid))
        |=> int'(free_cnt) == int'($past(free_cnt)) - int'($past(wr_cnt))
                              + int'($past(rd_cnt))); // R6
    AST_REFUSE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr_cnt > free_cnt && rd_cnt == '0) |=> $stable(free_cnt)); // R7

endmodule

// File: tb/test_fetch_group_queue.sv
`timescale 1ns/1ps
module test_fetch_group_queue;
    localparam int DEPTH = 12;
    localparam int WL    = 4;
    localparam int RL    = 2;
    localparam int DW    = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic [2:0]      wr_cnt = '0;
    logic [WL*DW-1:0] wr_data = '0;
    logic [1:0]      rd_cnt = '0;
    logic [RL*DW-1:0] rd_data;
    logic [RL-1:0]   rd_valid;
    logic [3:0]      free_cnt;

    fetch_group_queue i_fetch_group_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_cnt(wr_cnt), .wr_data(wr_data), .rd_cnt(rd_cnt),
        .rd_data(rd_data), .rd_valid(rd_valid), .free_cnt(free_cnt)
    );

    always #2 clk = ~clk;

    int model[$];
    int seq = 1;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one operation from a falling edge, update the model at the rising edge.
    task automatic cycle(bit f, int w, int r);
        int free_now;
        int take;
        flush  = f;
        wr_cnt = 3'(w);
        rd_cnt = 2'(r);
        for (int l = 0; l < WL; l++) wr_data[l*DW +: DW] = DW'(seq + l);
        @(posedge clk);
        free_now = DEPTH - model.size();
        if (f) begin
            model.delete();
        end else begin
            take = r;
            if (take > RL) take = RL;
            if (take > model.size()) take = model.size();
            for (int i = 0; i < take; i++) void'(model.pop_front());
            if (w <= WL && w <= free_now)
                for (int l = 0; l < w; l++) model.push_back(seq + l);
        end
        seq += WL;
        @(negedge clk);
        flush = 1'b0; wr_cnt = '0; rd_cnt = '0;
    endtask

    task automatic check_all(string tag_free, string tag_data);
        chk(tag_free, "free_cnt", int'(free_cnt), DEPTH - model.size());
        for (int k = 0; k < RL; k++) begin
            chk("R4", $sformatf("rd_valid[%0d]", k), int'(rd_valid[k]),
                (model.size() > k) ? 1 : 0);
            if (model.size() > k)
                chk(tag_data, $sformatf("rd_data lane %0d", k),
                    int'(rd_data[k*DW +: DW]), model[k]);
        end
    endtask

    // Empty the queue, move head to slot s, then hold o words.
    task automatic prepare(int s, int o);
        int left;
        cycle(1'b1, 0, 0);
        left = s;
        while (left > 0) begin
            cycle(1'b0, (left > WL) ? WL : left, 0);
            left -= (left > WL) ? WL : left;
        end
        while (model.size() > 0) cycle(1'b0, 0, 2);
        left = o;
        while (left > 0) begin
            cycle(1'b0, (left > WL) ? WL : left, 0);
            left -= (left > WL) ? WL : left;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int offsets[3] = '{0, 7, 11};
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R2", "R2");   // R2 reset state

        foreach (offsets[si]) begin
            for (int o = 0; o <= DEPTH; o++)
                for (int w = 0; w < 8; w++)
                    for (int r = 0; r < 4; r++)
                        for (int f = 0; f < 2; f++) begin
                            prepare(offsets[si], o);
                            if (f != 0)                          tag = "R5";
                            else if (w > WL || w > DEPTH - o)    tag = "R7";
                            else if (w > 0 && r > 0)             tag = "R6";
                            else if (w > 0)                      tag = "R1";
                            else                                 tag = "R3";
                            cycle(f[0], w, r);
                            check_all(tag, (offsets[si] != 0) ? "R8" : tag);
                        end
        end

        // R2: a full queue refuses any further group and reset clears it.
        prepare(0, DEPTH);
        cycle(1'b0, 1, 0);
        check_all("R2", "R2");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model.delete();
        @(negedge clk);
        check_all("R2", "R2");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule